// File: doc/BRIEF.md
# Seedable Pseudo-Random Sequence Generator

This block is a 16-bit shift register with linear XOR feedback. Each clock cycle it steps to the next word of a maximal-length pseudo-random sequence. It also presents the bit that leaves the register on that step as a serial stream. A compile-time parameter chooses how the feedback is built. In the external form, a single XOR of several state bits feeds the top of the register. In the internal form, the bit leaving the bottom is XORed into the tapped positions as the word shifts. Both forms use the polynomial x^16 + x^14 + x^13 + x^11 + 1, so every non-zero start point gives a cycle of 65535 words. The two forms run through those words in different orders.

A seed enters through a load strobe. While the strobe is held, the register keeps presenting the seed. Stepping resumes on the first cycle after the strobe drops. No state is guarded against lock-up. A zero seed is accepted and traps the register at zero until the next load or reset. The block has no notion of overflow or underflow: a non-zero sequence simply wraps back to its first word.

Top module: `lfsr_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, `state` becomes 16'hACE1 and `serial_out` becomes 0 after that edge, whatever `load` does.
- R2: When `load` is high (and `rst` low) at an edge, `state` equals `seed` one cycle later. It stays equal to `seed` for every further edge at which `load` remains high.
- R3: In the external-feedback form (`FORM` = FORM_FIB), each step moves bits 15..1 down to bits 14..0. The new bit 15 is the XOR of the old bits 0, 2, 3 and 5.
- R4: In the internal-feedback form (`FORM` = FORM_GAL), each step shifts the word right by one. If the old bit 0 was 1, the shifted word is XORed with 16'hB400, which sets taps at bits 15, 13, 12 and 10.
- R5: A zero seed, once loaded and released, keeps `state` at zero and `serial_out` at 0 on every step, for at least 17 steps.
- R6: In both forms, a non-zero state never steps to zero. Starting from 16'hACE1, the state first returns to 16'hACE1 after exactly 65535 steps.
- R7: After each step, `serial_out` equals bit 0 of the state as it was before that step. After a reset or a load, `serial_out` is 0.
- R8: Priority is reset over load over stepping. A load cancels the step of that cycle, and a reset cancels the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to the default seed |
| load | input | 1 | Seed strobe; the seed is held while it stays high |
| seed | input | 16 | Start value taken when `load` is high |
| state | output | 16 | Current register word |
| serial_out | output | 1 | Bit shifted out on the most recent step |

## Verification
Some properties are checked on every cycle. These are the load capture, the zero state trapping itself, a non-zero state staying non-zero, the serial bit matching the old bit 0, and the shift lanes of whichever form is built. Other behaviour is shown only by the bench's scenarios. That covers the exact feedback value on every step, the default word after reset, the priority of reset over load, and the full 65535-step period of both forms. The period run walks the whole non-zero sequence of both forms side by side. Each word is compared with an arithmetic model, and the bench confirms that the start word and zero never appear early.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

    // Register width and defaults shared by every instance
    localparam int          LFSR_W        = 16;
    localparam logic [15:0] DEFAULT_TAPS  = 16'hB400; // internal-form mask, x^16+x^14+x^13+x^11+1
    localparam logic [15:0] DEFAULT_SEED  = 16'hACE1;

    // Feedback arrangement chosen at build time
    typedef enum logic {
        FORM_FIB = 1'b0,   // one XOR of several bits feeds the top
        FORM_GAL = 1'b1    // leaving bit is XORed into tapped lanes
    } lfsr_form_e;

    // Per-cycle operation of the state register
    typedef enum logic [1:0] {
        OP_RESET = 2'd0,
        OP_LOAD  = 2'd1,
        OP_STEP  = 2'd2
    } lfsr_op_e;

    // Mirror the low w bits of a vector; the external form reads its
    // taps at the mirrored positions of the internal-form mask
    function automatic logic [63:0] mirror_bits(input logic [63:0] v, input int w);
        logic [63:0] r;
        r = '0;
        for (int i = 0; i < 64; i++) begin
            if (i < w) r[w - 1 - i] = v[i];
        end
        return r;
    endfunction

endpackage

// File: rtl/lfsr_ctrl.sv
module lfsr_ctrl
    import lfsr_pkg::*;
(
    input  logic     rst,
    input  logic     load,
    output lfsr_op_e op
);

    // Reset outranks load, load outranks stepping
    always_comb begin
        if (rst)       op = OP_RESET;
        else if (load) op = OP_LOAD;
        else           op = OP_STEP;
    end

endmodule

// File: rtl/lfsr_fib_step.sv
module lfsr_fib_step #(
    parameter int               WIDTH = 16,
    parameter logic [WIDTH-1:0] TAPS  = 16'h002D
) (
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] nxt,
    output logic             out_bit
);

    logic fb;

    // External feedback: parity of the tapped bits enters at the top
    always_comb begin
        fb      = ^(cur & TAPS);
        nxt     = {fb, cur[WIDTH-1:1]};
        out_bit = cur[0];
    end

endmodule

// File: rtl/lfsr_gal_step.sv
module lfsr_gal_step #(
    parameter int               WIDTH = 16,
    parameter logic [WIDTH-1:0] TAPS  = 16'hB400
) (
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] nxt,
    output logic             out_bit
);

    logic [WIDTH-1:0] shifted;

    // Internal feedback: the leaving bit toggles every tapped lane
    always_comb begin
        shifted = cur >> 1;
        nxt     = cur[0] ? (shifted ^ TAPS) : shifted;
        out_bit = cur[0];
    end

endmodule

// File: rtl/lfsr_state_reg.sv
module lfsr_state_reg
    import lfsr_pkg::*;
#(
    parameter int               WIDTH      = 16,
    parameter logic [WIDTH-1:0] RESET_SEED = 16'hACE1
) (
    input  logic             clk,
    input  lfsr_op_e         op,
    input  logic [WIDTH-1:0] seed,
    input  logic [WIDTH-1:0] nxt,
    input  logic             step_bit,
    output logic [WIDTH-1:0] state,
    output logic             serial_out
);

    always_ff @(posedge clk) begin
        case (op)
            OP_RESET: begin
                state      <= RESET_SEED;
                serial_out <= 1'b0;
            end
            OP_LOAD: begin
                state      <= seed;
                serial_out <= 1'b0;
            end
            default: begin
                state      <= nxt;
                serial_out <= step_bit;
            end
        endcase
    end

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (op == OP_RESET)
        (op == OP_LOAD) |=> (state == $past(seed)));                          // R2

    AST_ZERO_TRAP: assert property (@(posedge clk) disable iff (op == OP_RESET)
        (op == OP_STEP && state == '0) |=> (state == '0 && !serial_out));      // R5

    AST_NONZERO_KEPT: assert property (@(posedge clk) disable iff (op == OP_RESET)
        (op == OP_STEP && state != '0) |=> (state != '0));                     // R6

    AST_SERIAL_SOURCE: assert property (@(posedge clk) disable iff (op == OP_RESET)
        (op == OP_STEP) |=> (serial_out == $past(state[0])));                  // R7

    AST_SERIAL_CLEAR: assert property (@(posedge clk) disable iff (op == OP_RESET)
        (op == OP_LOAD) |=> !serial_out);                                      // R7

endmodule

// File: rtl/lfsr_gen.sv
module lfsr_gen
    import lfsr_pkg::*;
#(
    parameter lfsr_form_e       FORM       = FORM_FIB,
    parameter int               WIDTH      = LFSR_W,
    parameter logic [WIDTH-1:0] POLY_MASK  = DEFAULT_TAPS,
    parameter logic [WIDTH-1:0] RESET_SEED = DEFAULT_SEED
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] seed,
    output logic [WIDTH-1:0] state,
    output logic             serial_out
);

    // The external form reads its taps at the mirrored lanes
    localparam logic [WIDTH-1:0] FIB_TAPS = WIDTH'(mirror_bits(64'(POLY_MASK), WIDTH));

    lfsr_op_e         op;
    logic [WIDTH-1:0] nxt;
    logic             step_bit;

    lfsr_ctrl u_ctrl (
        .rst  (rst),
        .load (load),
        .op   (op)
    );

    generate
        if (FORM == FORM_FIB) begin : g_fib
            lfsr_fib_step #(.WIDTH(WIDTH), .TAPS(FIB_TAPS)) u_step (
                .cur     (state),
                .nxt     (nxt),
                .out_bit (step_bit)
            );

            AST_FIB_LANES: assert property (@(posedge clk) disable iff (rst)
                (!load) |=> (state[WIDTH-2:0] == $past(state[WIDTH-1:1])));    // R3
        end else begin : g_gal
            lfsr_gal_step #(.WIDTH(WIDTH), .TAPS(POLY_MASK)) u_step (
                .cur     (state),
                .nxt     (nxt),
                .out_bit (step_bit)
            );

            AST_GAL_TOP: assert property (@(posedge clk) disable iff (rst)
                (!load) |=> (state[WIDTH-1] == ($past(state[0]) & POLY_MASK[WIDTH-1]))); // R4
        end
    endgenerate

    lfsr_state_reg #(.WIDTH(WIDTH), .RESET_SEED(RESET_SEED)) u_reg (
        .clk        (clk),
        .op         (op),
        .seed       (seed),
        .nxt        (nxt),
        .step_bit   (step_bit),
        .state      (state),
        .serial_out (serial_out)
    );

endmodule

// File: tb/tb_lfsr_gen.sv
module tb_lfsr_gen;
    import lfsr_pkg::*;

    logic        clk  = 1'b0;
    logic        rst  = 1'b1;
    logic        load = 1'b0;
    logic [15:0] seed = 16'h0;
    logic [15:0] st_f, st_g;
    logic        so_f, so_g;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [15:0] ef, eg;
    logic        esf, esg;

    always #2 clk = ~clk;   // 250 MHz

    lfsr_gen #(.FORM(FORM_FIB)) dut (
        .clk(clk), .rst(rst), .load(load), .seed(seed),
        .state(st_f), .serial_out(so_f)
    );

    lfsr_gen #(.FORM(FORM_GAL)) dut_gal (
        .clk(clk), .rst(rst), .load(load), .seed(seed),
        .state(st_g), .serial_out(so_g)
    );

    // R3 recurrence: top gets parity of bits 0,2,3,5
    function automatic logic [15:0] model_fib(input logic [15:0] s);
        return {s[0] ^ s[2] ^ s[3] ^ s[5], s[15:1]};
    endfunction

    // R4 recurrence: shift right, apply 16'hB400 when old bit 0 set
    function automatic logic [15:0] model_gal(input logic [15:0] s);
        return (s >> 1) ^ (s[0] ? 16'hB400 : 16'h0000);
    endfunction

    task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive at the falling edge, let one rising edge pass, compare at the next falling edge
    task automatic cycle(input logic r, input logic l, input logic [15:0] s,
                         input string tf, input string tg);
        rst = r; load = l; seed = s;
        @(posedge clk);
        @(negedge clk);
        if (r) begin
            ef = 16'hACE1; eg = 16'hACE1; esf = 1'b0; esg = 1'b0;
        end else if (l) begin
            ef = s; eg = s; esf = 1'b0; esg = 1'b0;
        end else begin
            esf = ef[0]; ef = model_fib(ef);
            esg = eg[0]; eg = model_gal(eg);
        end
        check_val({tf, " state fib"}, 32'(st_f), 32'(ef));
        check_val({tg, " state gal"}, 32'(st_g), 32'(eg));
        check_val({tf, " serial fib"}, 32'(so_f), 32'(esf));
        check_val({tg, " serial gal"}, 32'(so_g), 32'(esg));
    endtask

    initial begin
        int early_f;
        int early_g;
        @(negedge clk);

        // R1: reset word and cleared serial bit
        cycle(1'b1, 1'b0, 16'h0000, "R1", "R1");
        cycle(1'b1, 1'b0, 16'h0000, "R1", "R1");
        // R8: reset wins over a simultaneous load
        cycle(1'b1, 1'b1, 16'h5555, "R8", "R8");

        // R6: full period from the default word, both forms side by side
        early_f = 0;
        early_g = 0;
        for (int n = 1; n <= 65535; n++) begin
            cycle(1'b0, 1'b0, 16'h0000, "R3 R7", "R4 R7");
            if (n < 65535) begin
                if (st_f == 16'hACE1 || st_f == 16'h0000) early_f++;
                if (st_g == 16'hACE1 || st_g == 16'h0000) early_g++;
            end
        end
        check_val("R6 fib early return or zero", 32'(early_f), 32'd0);
        check_val("R6 gal early return or zero", 32'(early_g), 32'd0);
        check_val("R6 fib back at start", 32'(st_f), 32'h0000ACE1);
        check_val("R6 gal back at start", 32'(st_g), 32'h0000ACE1);

        // R2/R5: zero seed held, then released and trapped
        for (int k = 0; k < 3; k++) cycle(1'b0, 1'b1, 16'h0000, "R2", "R2");
        for (int k = 0; k < 20; k++) cycle(1'b0, 1'b0, 16'h0000, "R5", "R5");

        // R2: non-zero seed held for several cycles
        for (int k = 0; k < 4; k++) cycle(1'b0, 1'b1, 16'h1234, "R2", "R2");
        for (int k = 0; k < 17; k++) cycle(1'b0, 1'b0, 16'h0000, "R3 R7", "R4 R7");

        // R8: a load in mid-run replaces the step of that cycle
        cycle(1'b0, 1'b1, 16'hFFFF, "R8", "R8");
        for (int k = 0; k < 17; k++) cycle(1'b0, 1'b0, 16'h0000, "R3 R7", "R4 R7");

        // R2/R3/R4: one-hot seeds over every bit position
        for (int i = 0; i < 16; i++) begin
            cycle(1'b0, 1'b1, 16'h0001 << i, "R2", "R2");
            for (int k = 0; k < 17; k++) cycle(1'b0, 1'b0, 16'h0000, "R3 R7", "R4 R7");
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R6 watchdog: actual run still busy expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule